// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers a wide set of level-sensitive interrupt lines into one request line for a processor. The lines are split into banks of 32; the number of banks is a parameter (3 or 4, so 96 or 128 lines). Every bank has its own synchronized input status, a mask, and a pending view that shows only the inputs that are unmasked. Software changes the mask through separate set and clear ports, so it never needs a read-modify-write sequence.

The processor line is sticky. Once it is raised it stays raised until software writes the recompute bit in the control register. That write re-evaluates the line from the pending bits of every bank. A handler therefore reads the pending registers, services the sources, and then writes the recompute bit to rearm the line. Access goes through a plain 32-bit register bus with a byte address. Read data is combinational from the address, and a write takes effect on the clock edge where the write strobe is high.

Top module: `banked_intc`

## Requirements
- R1: After reset every mask bit is 1, every pending register reads 0 and `irq_out` is 0.
- R2: Bank b's registers sit at byte address 0x80 + b*0x20 plus a local offset: 0x00 input status (read-only), 0x04 mask, 0x08 mask-clear port, 0x0C mask-set port, 0x18 pending. The control register is at byte address 0x48. The clear and set ports read as 0.
- R3: A change on `src_in` appears in the input status register after exactly two rising clock edges.
- R4: Writing the mask-set port sets every mask bit whose data bit is 1 and leaves bits whose data bit is 0 unchanged.
- R5: Writing the mask-clear port clears every mask bit whose data bit is 1 and leaves bits whose data bit is 0 unchanged.
- R6: The pending register equals input status AND NOT mask. It follows the present input level, with no latching of past pulses.
- R7: While `irq_out` is 0, any non-zero pending bit in any bank raises `irq_out` on the next rising edge.
- R8: While `irq_out` is 1 and no recompute write occurs, `irq_out` stays 1, even when all pending bits fall to 0.
- R9: A write to the control register with data bit 0 set makes `irq_out` equal, one edge later, to the OR of all pending bits seen in the write cycle. A control write with bit 0 clear has no effect, and the control register always reads 0.
- R10: Reads of an unmapped address return 0, and writes to one change nothing. Unmapped addresses include addresses whose low two bits are non-zero, unused local offsets, and banks at or above the configured count.
- R11: Writing the mask register itself loads all 32 mask bits from the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_BANKS*32 | Level-sensitive interrupt inputs; line n is bank n/32, bit n%32 |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The embedded assertions check on every cycle:
- the set and clear semantics of the mask, both for the bits written with 1 and for those written with 0;
- the sticky hold of the request line, its rise from a deasserted state, and its re-evaluation on a recompute write;
- zero read data for the control register and for misaligned addresses.

Only the bench's scenarios can show the following:
- the two-edge latency of the input synchronizer;
- the full address map, checked by a sweep of all 256 byte addresses;
- the reset state;
- that writes to absent banks and unused offsets leave no trace;
- the per-line path from input, through unmasking, to the request line, swept across every source.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int LINES      = 32;
    localparam int ADDR_W     = 8;
    localparam int BIDX_W     = 2;
    localparam int LOFF_W     = 5;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h48;

    localparam logic [LOFF_W-1:0] OFF_STAT = 5'h00;
    localparam logic [LOFF_W-1:0] OFF_MASK = 5'h04;
    localparam logic [LOFF_W-1:0] OFF_CLR  = 5'h08;
    localparam logic [LOFF_W-1:0] OFF_SET  = 5'h0C;
    localparam logic [LOFF_W-1:0] OFF_PEND = 5'h18;

    typedef struct packed {
        logic [LINES-1:0] mask;
    } bank_st_t;

    typedef struct packed {
        logic irq;
    } req_st_t;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W      = 96,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    input  logic             wr_mask,
    input  logic             wr_clr,
    input  logic             wr_set,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] mask_o,
    output logic [LINES-1:0] pend_o
);
    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_mask)     st_d.mask = wdata;
        else if (wr_set) st_d.mask = st_q.mask | wdata;
        else if (wr_clr) st_d.mask = st_q.mask & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mask: '1};
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign pend_o = raw & ~st_q.mask;

    // R4: ones set, zeros keep
    a_r4_set_ones: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask_o & $past(wdata)) == $past(wdata)));
    a_r4_set_keep: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask_o & ~$past(wdata)) == ($past(mask_o) & ~$past(wdata))));
    // R5: ones clear, zeros keep
    a_r5_clr_ones: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask_o & $past(wdata)) == '0));
    a_r5_clr_keep: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask_o | $past(wdata)) == ($past(mask_o) | $past(wdata))));
    // R11: direct load
    a_r11_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask_o == $past(wdata)));
endmodule

// File: rtl/intc_req.sv
module intc_req
    import intc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend,
    input  logic agree,
    output logic irq_o
);
    req_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (agree) st_d.irq = any_pend;
        else       st_d.irq = st_q.irq | any_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{irq: 1'b0};
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    a_r7_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && any_pend) |=> irq_o);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !agree) |=> irq_o);
    a_r9_recompute: assert property (@(posedge clk) disable iff (!rst_n)
        agree |=> (irq_o == $past(any_pend)));
endmodule

// File: rtl/banked_intc.sv
module banked_intc
    import intc_pkg::*;
#(
    parameter int NUM_BANKS   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BANKS*LINES-1:0] src_in,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [LINES-1:0]           bus_wdata,
    output logic [LINES-1:0]           bus_rdata,
    output logic                       irq_out
);
    localparam int SRC_W = NUM_BANKS * LINES;

    logic [SRC_W-1:0]                   raw_all;
    logic [NUM_BANKS-1:0][LINES-1:0]    mask_v;
    logic [NUM_BANKS-1:0][LINES-1:0]    pend_v;
    logic [BIDX_W-1:0]                  bidx;
    logic [LOFF_W-1:0]                  loff;
    logic                               bank_ok;
    logic                               agree;
    logic                               any_pend;

    intc_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (src_in),
        .dout (raw_all)
    );

    assign bidx    = bus_addr[6:5];
    assign loff    = bus_addr[4:0];
    assign bank_ok = bus_addr[7] && (bus_addr[1:0] == 2'b00) && (32'(bidx) < NUM_BANKS);
    assign agree   = bus_we && (bus_addr == CTRL_ADDR) && bus_wdata[0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = bank_ok && (bidx == BIDX_W'(b));
        intc_bank u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw    (raw_all[b*LINES +: LINES]),
            .wr_mask(bus_we && hit && (loff == OFF_MASK)),
            .wr_clr (bus_we && hit && (loff == OFF_CLR)),
            .wr_set (bus_we && hit && (loff == OFF_SET)),
            .wdata  (bus_wdata),
            .mask_o (mask_v[b]),
            .pend_o (pend_v[b])
        );
    end

    assign any_pend = |pend_v;

    intc_req u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_pend(any_pend),
        .agree   (agree),
        .irq_o   (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_ok && (bidx == BIDX_W'(b))) begin
                case (loff)
                    OFF_STAT: bus_rdata = raw_all[b*LINES +: LINES];
                    OFF_MASK: bus_rdata = mask_v[b];
                    OFF_PEND: bus_rdata = pend_v[b];
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end

    a_r9_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == CTRL_ADDR) |-> (bus_rdata == '0));
    a_r10_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_banked_intc.sv
module tb_banked_intc;
    localparam int NB = 3;
    localparam int SW = NB * 32;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] src = '0;
    logic [7:0]    addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] mask_m [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_intc #(.NUM_BANKS(NB), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .src_in(src), .bus_addr(addr),
        .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    function automatic logic [31:0] exp_rd(input int a);
        int b;
        logic [31:0] raw;
        if (a < 8'h80 || (a % 4) != 0) return 32'h0;
        b = (a - 8'h80) / 32;
        if (b >= NB) return 32'h0;
        raw = src[b*32 +: 32];
        case ((a - 8'h80) % 32)
            0:  return raw;
            4:  return mask_m[b];
            24: return raw & ~mask_m[b];
            default: return 32'h0;
        endcase
    endfunction

    task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
        @(negedge clk);
        addr = 8'(a);
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < 256; a++) rd_chk(req, a, exp_rd(a));
    endtask

    function automatic logic [7:0] badr(input int b, input int off);
        return 8'(8'h80 + b * 32 + off);
    endfunction

    initial begin
        for (int b = 0; b < NB; b++) mask_m[b] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R2 and R10 map via full sweep
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        sweep("R1/R2/R10 reset sweep");

        // R3 synchronizer latency
        @(negedge clk);
        src = {32'h0000_8001, 32'h00F0_0000, 32'hA5A5_0003};
        @(negedge clk);
        addr = badr(0, 0); #1;
        chk("R3 one edge old", rdata, 32'h0);
        @(negedge clk); #1;
        chk("R3 two edges new", rdata, 32'hA5A5_0003);
        chk("R1 masked no irq", {31'b0, irq}, 32'h0);

        // R5 clear port, R7 raise timing
        wr(badr(1, 8), 32'h0030_0000);
        mask_m[1] &= ~32'h0030_0000;
        chk("R7 irq not before edge", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R7 irq raised", {31'b0, irq}, 32'h1);
        rd_chk("R5 clr mask", badr(1, 4), 32'hFFCF_FFFF);
        rd_chk("R6 pending", badr(1, 24), 32'h0030_0000);
        rd_chk("R2 clr port reads 0", badr(1, 8), 32'h0);

        // R8 hold after source drops, R6 level
        @(negedge clk);
        src = '0;
        repeat (4) @(negedge clk);
        chk("R8 irq held", {31'b0, irq}, 32'h1);
        rd_chk("R6 pending follows level", badr(1, 24), 32'h0);

        // R9 control write with bit0 clear: no effect
        wr(8'h48, 32'hFFFF_FFFE);
        @(negedge clk);
        chk("R9 bit0 clear no effect", {31'b0, irq}, 32'h1);
        rd_chk("R9 ctrl reads 0", 8'h48, 32'h0);
        wr(8'h48, 32'h1);
        chk("R9 recompute drops irq", {31'b0, irq}, 32'h0);

        // R9 recompute with pending present keeps irq
        @(negedge clk);
        src[32 + 20] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 level raises again", {31'b0, irq}, 32'h1);
        wr(8'h48, 32'h1);
        @(negedge clk);
        chk("R9 recompute keeps irq", {31'b0, irq}, 32'h1);

        // R4 set port, zeros keep
        wr(badr(1, 12), 32'h0010_0000);
        mask_m[1] |= 32'h0010_0000;
        rd_chk("R4 set port", badr(1, 4), 32'hFFDF_FFFF);
        wr(8'h48, 32'h1);
        chk("R9 recompute after remask", {31'b0, irq}, 32'h0);

        // R11 direct mask write
        wr(badr(2, 4), 32'h0F0F_00FF);
        mask_m[2] = 32'h0F0F_00FF;
        rd_chk("R11 mask load", badr(2, 4), 32'h0F0F_00FF);
        wr(badr(2, 12), 32'hF000_0000);
        mask_m[2] |= 32'hF000_0000;
        wr(badr(2, 8), 32'h0000_000F);
        mask_m[2] &= ~32'h0000_000F;
        rd_chk("R4/R5 mixed", badr(2, 4), 32'hFF0F_00F0);

        // R10 writes to unmapped space
        wr(badr(3, 4), 32'h0);
        wr(badr(3, 8), 32'hFFFF_FFFF);
        wr(8'h89, 32'hFFFF_FFFF);
        wr(8'h8A, 32'hFFFF_FFFF);
        wr(badr(0, 16), 32'h0);
        wr(badr(1, 28), 32'h0);
        wr(8'h00, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R10 no irq from unmapped writes", {31'b0, irq}, 32'h0);
        sweep("R10 state after unmapped writes");

        // restore all masks and clear irq
        for (int b = 0; b < NB; b++) begin
            wr(badr(b, 12), 32'hFFFF_FFFF);
            mask_m[b] = 32'hFFFF_FFFF;
        end
        @(negedge clk);
        src = '0;
        repeat (3) @(negedge clk);
        wr(8'h48, 32'h1);
        chk("R9 clean start", {31'b0, irq}, 32'h0);

        // per-line sweep: R3, R5, R6, R7, R4, R9
        for (int s = 0; s < SW; s++) begin
            int b;
            logic [31:0] bit1;
            b = s / 32;
            bit1 = 32'h1 << (s % 32);
            @(negedge clk);
            src = '0;
            src[s] = 1'b1;
            repeat (3) @(negedge clk);
            chk("R6 masked line no irq", {31'b0, irq}, 32'h0);
            rd_chk("R3 raw line", badr(b, 0), bit1);
            wr(badr(b, 8), bit1);
            @(negedge clk);
            chk("R7 line raises irq", {31'b0, irq}, 32'h1);
            rd_chk("R6 pending line", badr(b, 24), bit1);
            wr(badr(b, 12), bit1);
            wr(8'h48, 32'h1);
            chk("R9 line recompute clears", {31'b0, irq}, 32'h0);
        end

        @(negedge clk);
        src = {32'h1234_5678, 32'h9ABC_DEF0, 32'h0F1E_2D3C};
        repeat (3) @(negedge clk);
        sweep("R2 final sweep");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule